// File: doc/BRIEF.md
# Pulse Interval Capture Timer

This block is one up-counting timer channel that measures the time between qualifying edges on an input pin. When it is running, the counter advances by one on every cycle in which the count-clock enable is high. On each qualifying edge the channel does three things in the same cycle: it copies the counter into a capture register, clears the counter and raises a one-cycle interrupt. A software start write made while the channel is running does the same. Software reads the capture register to obtain the interval in count ticks. A status bit reports whether the counter wrapped during that interval.

The pin is passed through a two-stage synchronizer. An optional filter can also be switched in, which accepts a new level only after it has been seen on consecutive samples. Control and status use a small register port. Start and stop are self-clearing trigger bits. While the channel runs, only the edge selection may be changed. A unit enable input holds the whole channel in its reset state while it is low.

Top module: `icap_timer`

## Requirements
- R1: A start write (TRIG address 1, bit 0) made while stopped sets the running bit (STAT address 2, bit 0) and clears the counter to 0 on the same edge.
- R2: When the start-interrupt bit (CTRL address 0, bit 2) is 1, a start from the stopped state raises a one-cycle interrupt. When that bit is 0, no interrupt is raised at start.
- R3: While running, the counter (COUNT address 4) increments by one on each clock with the count enable high, and holds on any clock with the enable low.
- R4: A qualifying edge while running loads the counter into the capture register (CAP address 3), clears the counter and pulses the interrupt for one cycle. With the count enable high on every cycle, edges N cycles apart capture N-1.
- R5: A start write made while running acts as a capture: the captured value, the counter clear and the interrupt are the same as for an edge.
- R6: Every capture rewrites the overflow bit (STAT bit 1). It is set to 1 if the counter wrapped from all-ones to 0 since the last capture or start, including a wrap in the capture cycle itself. Otherwise it is cleared to 0.
- R7: A stop write (TRIG bit 1) clears the running bit. The counter and the overflow bit then hold their values, and pin edges cause no capture and no interrupt.
- R8: The edge field (CTRL bits 1:0) selects the qualifying edges: 00 selects falling, 01 selects rising, 10 selects both, and 11 selects none.
- R9: With the filter bit (CTRL bit 3) at 1, the pin level must be the same on 2 consecutive synchronized samples before it is accepted, so a one-cycle pulse is ignored. With the filter bit at 0, a one-cycle pulse yields two edges one cycle apart.
- R10: While running, a CTRL write updates only the edge field. The start-interrupt bit and the filter bit keep their values.
- R11: The TRIG address always reads 0.
- R12: While the unit enable is 0, every register reads its reset value of 0, and writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_en | input | 1 | Unit enable; 0 holds the channel in reset |
| cnt_tick | input | 1 | Count-clock enable from the prescaler |
| pin_in | input | 1 | Measured pin, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | W | Write data |
| rd_addr | input | AW | Read address, combinational read |
| rd_data | output | W | Read data |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the channel with W=8. At that width the counter wraps after 256 ticks, so the overflow cases can be reached in a few hundred cycles: a wrapped interval, the clearing capture that follows it, and a wrap that lands in the capture cycle itself. The synchronizer depth and the filter length stay at their defaults of 2. The count enable is held high, so the expected captures follow directly from how many cycles apart the bench changes the pin, and the fixed input latency cancels. That includes the zero capture produced by an unfiltered one-cycle glitch.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_sel_e;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_TRIG  = 3'd1;
  localparam logic [2:0] RA_STAT  = 3'd2;
  localparam logic [2:0] RA_CAP   = 3'd3;
  localparam logic [2:0] RA_COUNT = 3'd4;

  // Qualifying-edge test on the accepted level and its previous value.
  function automatic logic edge_hit(edge_sel_e sel, logic cur, logic prv);
    case (sel)
      EDGE_FALL: return prv & ~cur;
      EDGE_RISE: return cur & ~prv;
      EDGE_BOTH: return cur ^ prv;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/icap_in_cond.sv
module icap_in_cond
  import icap_pkg::*;
#(
  parameter int SYNC     = 2,
  parameter int FILT_LEN = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      pin_in,
  input  logic      filt_en,
  input  edge_sel_e sel,
  output logic      hit
);
  localparam int HW = FILT_LEN - 1;

  logic [SYNC-1:0] sync_q;
  logic [HW-1:0]   hist_q;
  logic            lvl_q, lvl_d_q, s_in, stable;

  assign s_in = sync_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sync_q <= '0;
    else if (clr) sync_q <= '0;
    else          sync_q <= {sync_q[SYNC-2:0], pin_in};
  end

  generate
    if (HW == 1) begin : g_hist1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hist_q <= '0;
        else if (clr) hist_q <= '0;
        else          hist_q <= s_in;
      end
    end else begin : g_histn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hist_q <= '0;
        else if (clr) hist_q <= '0;
        else          hist_q <= {hist_q[HW-2:0], s_in};
      end
    end
  endgenerate

  assign stable = (&{hist_q, s_in}) | ~(|{hist_q, s_in});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      lvl_d_q <= 1'b0;
    end else if (clr) begin
      lvl_q   <= 1'b0;
      lvl_d_q <= 1'b0;
    end else begin
      lvl_q   <= filt_en ? (stable ? s_in : lvl_q) : s_in;
      lvl_d_q <= lvl_q;
    end
  end

  assign hit = edge_hit(sel, lvl_q, lvl_d_q);

endmodule

// File: rtl/icap_regs.sv
module icap_regs
  import icap_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          unit_en,
  input  logic          running,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  output edge_sel_e     sel,
  output logic          sirq_en,
  output logic          filt_en,
  output logic          start_req,
  output logic          stop_req
);
  logic wr_ctrl, wr_trig;

  assign wr_ctrl   = unit_en & wr_en & (wr_addr == AW'(RA_CTRL));
  assign wr_trig   = unit_en & wr_en & (wr_addr == AW'(RA_TRIG));
  assign start_req = wr_trig & wr_data[0];
  assign stop_req  = wr_trig & wr_data[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel     <= EDGE_FALL;
      sirq_en <= 1'b0;
      filt_en <= 1'b0;
    end else if (!unit_en) begin
      sel     <= EDGE_FALL;
      sirq_en <= 1'b0;
      filt_en <= 1'b0;
    end else if (wr_ctrl) begin
      sel <= edge_sel_e'(wr_data[1:0]);
      if (!running) begin
        sirq_en <= wr_data[2];
        filt_en <= wr_data[3];
      end
    end
  end

endmodule

// File: rtl/icap_core.sv
module icap_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         unit_en,
  input  logic         tick,
  input  logic         start_req,
  input  logic         stop_req,
  input  logic         edge_hit,
  input  logic         sirq_en,
  output logic         running,
  output logic [W-1:0] count,
  output logic [W-1:0] cap,
  output logic         ovf,
  output logic         irq,
  output logic         cap_evt,
  output logic         wrap_now,
  output logic         start_idle,
  output logic         stop_evt
);
  logic wrapped_q;

  function automatic logic [W-1:0] count_next(logic [W-1:0] c);
    return c + W'(1);
  endfunction

  assign stop_evt   = unit_en & stop_req;
  assign start_idle = unit_en & start_req & ~stop_req & ~running;
  assign cap_evt    = unit_en & ~stop_req & running & (edge_hit | start_req);
  assign wrap_now   = running & tick & (&count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0; count <= '0; cap <= '0;
      ovf <= 1'b0; irq <= 1'b0; wrapped_q <= 1'b0;
    end else if (!unit_en) begin
      running <= 1'b0; count <= '0; cap <= '0;
      ovf <= 1'b0; irq <= 1'b0; wrapped_q <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (stop_evt) begin
        running <= 1'b0;
      end else if (start_idle) begin
        running   <= 1'b1;
        count     <= '0;
        wrapped_q <= 1'b0;
        irq       <= sirq_en;
      end else if (cap_evt) begin
        cap       <= count;
        count     <= '0;
        ovf       <= wrapped_q | wrap_now;
        wrapped_q <= 1'b0;
        irq       <= 1'b1;
      end else if (running && tick) begin
        count <= count_next(count);
        if (wrap_now) wrapped_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/icap_timer.sv
module icap_timer
  import icap_pkg::*;
#(
  parameter int W        = 16,
  parameter int AW       = 3,
  parameter int SYNC     = 2,
  parameter int FILT_LEN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          unit_en,
  input  logic          cnt_tick,
  input  logic          pin_in,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          irq
);
  edge_sel_e    sel;
  logic         sirq_en, filt_en, start_req, stop_req, hit;
  logic         running, ovf, cap_evt, wrap_now, start_idle, stop_evt;
  logic [W-1:0] count, cap;

  icap_in_cond #(.SYNC(SYNC), .FILT_LEN(FILT_LEN)) u_in (
    .clk(clk), .rst_n(rst_n), .clr(~unit_en), .pin_in(pin_in),
    .filt_en(filt_en), .sel(sel), .hit(hit)
  );

  icap_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .running(running),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sel(sel), .sirq_en(sirq_en), .filt_en(filt_en),
    .start_req(start_req), .stop_req(stop_req)
  );

  icap_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .tick(cnt_tick),
    .start_req(start_req), .stop_req(stop_req), .edge_hit(hit),
    .sirq_en(sirq_en), .running(running), .count(count), .cap(cap),
    .ovf(ovf), .irq(irq), .cap_evt(cap_evt), .wrap_now(wrap_now),
    .start_idle(start_idle), .stop_evt(stop_evt)
  );

  always_comb begin
    case (rd_addr)
      AW'(RA_CTRL):  rd_data = W'({filt_en, sirq_en, sel});
      AW'(RA_STAT):  rd_data = W'({ovf, running});
      AW'(RA_CAP):   rd_data = cap;
      AW'(RA_COUNT): rd_data = count;
      default:       rd_data = '0;
    endcase
  end

endmodule

// File: rtl/icap_timer_chk.sv
module icap_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         unit_en,
  input logic         cnt_tick,
  input logic         running,
  input logic [W-1:0] count,
  input logic [W-1:0] cap,
  input logic         ovf,
  input logic         irq,
  input logic         cap_evt,
  input logic         wrap_now,
  input logic         start_idle,
  input logic         stop_evt
);
  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_idle |=> (running && count == '0));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_en && running && cnt_tick && !cap_evt && !stop_evt)
      |=> (!unit_en || count == W'($past(count) + 1)));

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (!unit_en || (cap == $past(count) && count == '0 && irq)));

  assert_wrap_sets_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && wrap_now) |=> (!unit_en || ovf));

  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !running);

  assert_stopped_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start_idle && unit_en)
      |=> (!unit_en || ($stable(count) && $stable(ovf) && !irq)));

  assert_unit_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_en |=> (count == '0 && cap == '0 && !running && !ovf && !irq));

endmodule

bind icap_timer icap_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .cnt_tick(cnt_tick),
  .running(running), .count(count), .cap(cap), .ovf(ovf), .irq(irq),
  .cap_evt(cap_evt), .wrap_now(wrap_now), .start_idle(start_idle),
  .stop_evt(stop_evt)
);

// File: tb/test_icap_timer.sv
module test_icap_timer;
  localparam int W  = 8;
  localparam int AW = 3;
  localparam logic [AW-1:0] A_CTRL = 3'd0, A_TRIG = 3'd1, A_STAT = 3'd2,
                            A_CAP = 3'd3, A_COUNT = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0, unit_en = 1'b0, cnt_tick = 1'b1, pin_in = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = A_CAP;
  logic [W-1:0]  wr_data = '0;
  logic [W-1:0]  rd_data;
  logic          irq;

  int total = 0, bad = 0;
  bit done = 1'b0;

  typedef struct { bit chk; int val; string tag; } exp_t;
  exp_t q[$];
  exp_t e;

  always #5 clk = ~clk;

  icap_timer #(.W(W), .AW(AW)) i_icap_timer (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .cnt_tick(cnt_tick),
    .pin_in(pin_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(string r, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic push(bit c, int v, string t);
    exp_t x;
    x.chk = c; x.val = v; x.tag = t;
    q.push_back(x);
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, int d);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(logic [AW-1:0] a, int exp, string r);
    rd_addr = a;
    #1;
    check(r, int'(rd_data), exp);
    rd_addr = A_CAP;
  endtask

  task automatic rd_val(logic [AW-1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
    rd_addr = A_CAP;
  endtask

  // Monitor: every interrupt pops one expected item and compares the capture.
  always @(posedge clk) begin
    #2;
    if (irq) begin
      if (q.size() == 0) begin
        check("R7 unexpected irq", 1, 0);
      end else begin
        e = q.pop_front();
        if (e.chk) check(e.tag, int'(rd_data), e.val);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c1;
    hold(3);
    rst_n = 1'b1;
    hold(2);
    rd_chk(A_STAT, 0, "R12 reset STAT");
    rd_chk(A_CAP, 0, "R12 reset CAP");
    rd_chk(A_COUNT, 0, "R12 reset COUNT");
    rd_chk(A_CTRL, 0, "R12 reset CTRL");
    unit_en = 1'b1;
    hold(1);

    // R2: start interrupt on, rising edges
    wr(A_CTRL, 4'b0101);
    push(1'b1, 0, "R2 start irq");
    wr(A_TRIG, 1);
    rd_chk(A_COUNT, 0, "R1 count cleared");
    rd_chk(A_STAT, 1, "R1 running");
    hold(5);
    rd_chk(A_COUNT, 5, "R3 count step");
    cnt_tick = 1'b0;
    hold(4);
    rd_chk(A_COUNT, 5, "R3 hold without tick");
    cnt_tick = 1'b1;
    rd_chk(A_TRIG, 0, "R11 trig reads 0");

    // R4: rising edges 20 cycles apart
    pin_in = 1'b1; push(1'b0, 0, "first");
    hold(10); pin_in = 1'b0; hold(10);
    push(1'b1, 19, "R4 interval 20"); pin_in = 1'b1;
    hold(10); pin_in = 1'b0; hold(6);
    push(1'b1, 15, "R4 interval 16"); pin_in = 1'b1;
    hold(10);

    // R10: only edge field changes while running
    wr(A_CTRL, 4'b1010);
    rd_chk(A_CTRL, 6, "R10 ctrl locked");
    wr(A_CTRL, 4'b0001);
    rd_chk(A_CTRL, 5, "R10 edge restored");

    // R5: start while running captures
    push(1'b0, 0, "first start capture");
    wr(A_TRIG, 1);
    hold(14);
    push(1'b1, 14, "R5 start capture");
    wr(A_TRIG, 1);
    hold(5);
    pin_in = 1'b0; hold(5);
    push(1'b0, 0, "rebase"); pin_in = 1'b1;
    hold(10); pin_in = 1'b0; hold(290);

    // R6: wrapped interval, then clear, then wrap in the capture cycle
    push(1'b1, 43, "R6 wrapped cap"); pin_in = 1'b1;
    hold(10);
    rd_chk(A_STAT, 3, "R6 ovf set");
    pin_in = 1'b0; hold(10);
    push(1'b1, 19, "R6 short cap"); pin_in = 1'b1;
    hold(10);
    rd_chk(A_STAT, 1, "R6 ovf cleared");
    pin_in = 1'b0; hold(246);
    push(1'b1, 255, "R6 same-cycle wrap cap"); pin_in = 1'b1;
    hold(10);
    rd_chk(A_STAT, 3, "R6 same-cycle wrap ovf");

    // R7: stop
    wr(A_TRIG, 2);
    rd_chk(A_STAT, 2, "R7 stopped ovf kept");
    rd_val(A_COUNT, c1);
    hold(5);
    rd_chk(A_COUNT, c1, "R7 count held");
    pin_in = 1'b0; hold(5); pin_in = 1'b1; hold(8);
    rd_chk(A_CAP, 255, "R7 no capture when stopped");

    // R9 filter off, both edges, no start irq (R2)
    wr(A_CTRL, 4'b0010);
    rd_chk(A_CTRL, 2, "R8 ctrl both");
    wr(A_TRIG, 1);
    hold(3);
    push(1'b0, 0, "first"); pin_in = 1'b0;
    hold(10);
    push(1'b1, 9, "R8 both edges interval");
    push(1'b1, 0, "R9 unfiltered glitch");
    pin_in = 1'b1; hold(1); pin_in = 1'b0;
    hold(10);
    wr(A_TRIG, 2);

    // R9 filter on
    wr(A_CTRL, 4'b1010);
    rd_chk(A_CTRL, 10, "R9 filter set");
    wr(A_TRIG, 1);
    hold(3);
    push(1'b0, 0, "first"); pin_in = 1'b1;
    hold(10); pin_in = 1'b0; hold(1); pin_in = 1'b1; hold(9);
    push(1'b1, 19, "R9 glitch filtered"); pin_in = 1'b0;
    hold(10);
    wr(A_TRIG, 2);

    // R8 falling only
    wr(A_CTRL, 0);
    wr(A_TRIG, 1);
    hold(3);
    pin_in = 1'b1; hold(5);
    push(1'b0, 0, "first"); pin_in = 1'b0;
    hold(5); pin_in = 1'b1; hold(7);
    push(1'b1, 11, "R8 falling only"); pin_in = 1'b0;
    hold(10);

    // R12 unit disable
    unit_en = 1'b0;
    hold(1);
    rd_chk(A_STAT, 0, "R12 STAT off");
    rd_chk(A_COUNT, 0, "R12 COUNT off");
    rd_chk(A_CAP, 0, "R12 CAP off");
    wr(A_CTRL, 4'hF);
    rd_chk(A_CTRL, 0, "R12 write ignored");
    wr(A_TRIG, 1);
    rd_chk(A_STAT, 0, "R12 start ignored");
    hold(5);
    check("R4 pending irqs", q.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule